// File: doc/BRIEF.md
# Accumulator Execution Unit with Multiplier-Quotient Extension

This block executes the operations of a one-address instruction set. The accumulator is implied by every operation: it is never named in the instruction word. It is both the source of the first operand and the place the result goes. The second operand, where one is needed, arrives from memory alongside the decoded operation code. A multiplier-quotient register extends the accumulator to double width for signed multiply and divide.

Loads, arithmetic, bitwise logic and shifts finish in one clock. A store sends a single-cycle write request that carries the accumulator value and the address supplied with the operation. Multiply and divide run on an iterative shift-add or shift-subtract engine. They keep `busy` high until the register pair holds the result. Instruction fetch, program counter and branching sit outside this block.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `acc`, `mq`, `flag_c`, `flag_z`, `flag_n`, `div_err`, `busy` and `st_valid` are all zero.
- R2: An accepted LOAD (`op_code` 1) places `mem_operand` in `acc` on the next cycle; `mq` and the flags keep their values.
- R3: An accepted STORE (`op_code` 2) raises `st_valid` for exactly one cycle, with `st_addr` equal to `mem_addr` and `st_data` equal to the accumulator value when the store was accepted; `acc` does not change.
- R4: ADD (`op_code` 3) and SUB (`op_code` 4) write `acc` modulo 2^16. `flag_c` is the carry out for ADD and the unsigned borrow for SUB. `flag_z` shows a zero result and `flag_n` shows result bit 15. No other operation changes the three flags.
- R5: AND (5), OR (6) and XOR (7) combine `acc` bitwise with `mem_operand`; NOT (8) inverts `acc` and ignores `mem_operand`.
- R6: Shifts move `acc` by `mem_operand[3:0]` places. SHL (9) fills with zero from the right, SHR (10) fills with zero from the left, and SAR (11) copies bit 15 into the vacated left positions.
- R7: MUL (`op_code` 12) forms the signed 32-bit product of `acc` and `mem_operand`. The upper 16 bits go to `mq` and the lower 16 bits go to `acc`. For example, 0x6000 times 0x6000 leaves `mq`=0x2400 and `acc`=0x0000.
- R8: DIV (`op_code` 13) divides the signed 32-bit value `{mq,acc}` by the signed `mem_operand`. It truncates toward zero, places the quotient in `acc`, and places the remainder, carrying the sign of the dividend, in `mq`.
- R9: After MUL or a valid DIV is accepted, `busy` is high for exactly 17 cycles. It falls on the cycle the result appears. Any operation presented while `busy` is high is ignored.
- R10: A DIV whose divisor is zero, or whose dividend upper half has magnitude at least that of the divisor, sets `div_err`. It leaves `acc` and `mq` unchanged and does not raise `busy`. The next accepted operation (NOP, `op_code` 0, included) clears `div_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present; accepted when `busy` is low |
| op_code | input | 4 | Decoded operation |
| mem_operand | input | 16 | Memory operand |
| mem_addr | input | 8 | Memory address of the operation |
| acc | output | 16 | Accumulator |
| mq | output | 16 | Multiplier-quotient register |
| flag_c | output | 1 | Carry/borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| div_err | output | 1 | Divide fault flag |
| busy | output | 1 | Iterative multiply/divide in progress |
| st_valid | output | 1 | Store request strobe |
| st_addr | output | 8 | Store address |
| st_data | output | 16 | Store data |

## Verification
The hardest state to reach is a signed divide with a chosen dividend. No operation loads `mq` directly, so the upper half of the dividend can only come from a preceding multiply. The stimulus therefore loads a value and multiplies it by one or by a small factor to build each dividend, including negative ones whose upper half is all ones, before issuing DIV. The overflow fault is reached the same way, by leaving a large upper half behind from a multiply by 0x8000.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_NOT   = 4'd8,
    OP_SHL   = 4'd9,
    OP_SHR   = 4'd10,
    OP_SAR   = 4'd11,
    OP_MUL   = 4'd12,
    OP_DIV   = 4'd13
  } op_e;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_RUN  = 2'd1,
    MD_FIN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] m,
  output logic [W-1:0] res,
  output logic         wr_ac,
  output logic         upd_flags,
  output logic         cy
);
  localparam int SHW = $clog2(W);

  logic [W:0]     wide;
  logic [SHW-1:0] sh;

  assign sh = m[SHW-1:0];

  always_comb begin
    res       = ac;
    wr_ac     = 1'b0;
    upd_flags = 1'b0;
    cy        = 1'b0;
    wide      = '0;
    case (op)
      OP_LOAD: begin res = m; wr_ac = 1'b1; end
      OP_ADD: begin
        wide = {1'b0, ac} + {1'b0, m};
        res = wide[W-1:0]; cy = wide[W]; wr_ac = 1'b1; upd_flags = 1'b1;
      end
      OP_SUB: begin
        wide = {1'b0, ac} - {1'b0, m};
        res = wide[W-1:0]; cy = wide[W]; wr_ac = 1'b1; upd_flags = 1'b1;
      end
      OP_AND: begin res = ac & m; wr_ac = 1'b1; end
      OP_OR:  begin res = ac | m; wr_ac = 1'b1; end
      OP_XOR: begin res = ac ^ m; wr_ac = 1'b1; end
      OP_NOT: begin res = ~ac;    wr_ac = 1'b1; end
      OP_SHL: begin res = ac << sh; wr_ac = 1'b1; end
      OP_SHR: begin res = ac >> sh; wr_ac = 1'b1; end
      OP_SAR: begin res = W'($signed(ac) >>> sh); wr_ac = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv
  import acc_exec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_div,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  logic [W-1:0] m,
  output logic         div_fault,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int CW = $clog2(W);

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  md_state_e      state;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   hi_r, lo_r, mm_r;
  logic           div_r, neg_a, neg_b;

  logic [2*W-1:0] dvd, dvd_mag, prod, prod_s;
  logic [W-1:0]   m_mag;
  logic [W:0]     msum, trial;
  logic           ge;

  assign dvd     = {mq, ac};
  assign dvd_mag = dvd[2*W-1] ? (~dvd + 1'b1) : dvd;
  assign m_mag   = mag(m);
  assign div_fault = (m == '0) || (dvd_mag[2*W-1:W] >= m_mag);

  // one iteration of each engine
  assign msum  = {1'b0, hi_r} + (lo_r[0] ? {1'b0, mm_r} : '0);
  assign trial = {hi_r, lo_r[W-1]};
  assign ge    = trial >= {1'b0, mm_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MD_IDLE;
      cnt   <= '0;
      hi_r  <= '0;
      lo_r  <= '0;
      mm_r  <= '0;
      div_r <= 1'b0;
      neg_a <= 1'b0;
      neg_b <= 1'b0;
    end else begin
      case (state)
        MD_IDLE: if (start) begin
          state <= MD_RUN;
          cnt   <= '0;
          div_r <= is_div;
          mm_r  <= m_mag;
          if (is_div) begin
            hi_r  <= dvd_mag[2*W-1:W];
            lo_r  <= dvd_mag[W-1:0];
            neg_a <= mq[W-1] ^ m[W-1];
            neg_b <= mq[W-1];
          end else begin
            hi_r  <= '0;
            lo_r  <= mag(ac);
            neg_a <= ac[W-1] ^ m[W-1];
            neg_b <= 1'b0;
          end
        end
        MD_RUN: begin
          if (div_r) begin
            hi_r <= ge ? W'(trial - {1'b0, mm_r}) : trial[W-1:0];
            lo_r <= {lo_r[W-2:0], ge};
          end else begin
            hi_r <= msum[W:1];
            lo_r <= {msum[0], lo_r[W-1:1]};
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) state <= MD_FIN;
        end
        default: state <= MD_IDLE;
      endcase
    end
  end

  assign busy   = (state != MD_IDLE);
  assign done   = (state == MD_FIN);
  assign prod   = {hi_r, lo_r};
  assign prod_s = neg_a ? (~prod + 1'b1) : prod;

  always_comb begin
    if (div_r) begin
      res_lo = neg_a ? (~lo_r + 1'b1) : lo_r;
      res_hi = neg_b ? (~hi_r + 1'b1) : hi_r;
    end else begin
      res_lo = prod_s[W-1:0];
      res_hi = prod_s[2*W-1:W];
    end
  end

  // R9: the engine only starts from rest, and finishing returns it to rest
  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  p_run_count_r9: assert property (@(posedge clk) disable iff (rst)
    (state == MD_RUN && cnt != CW'(W-1)) |=> (state == MD_RUN));
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [W-1:0]  mem_operand,
  input  logic [AW-1:0] mem_addr,
  output logic [W-1:0]  acc,
  output logic [W-1:0]  mq,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          div_err,
  output logic          busy,
  output logic          st_valid,
  output logic [AW-1:0] st_addr,
  output logic [W-1:0]  st_data
);
  op_e          op;
  logic [W-1:0] ac_r, mq_r, alu_res, md_hi, md_lo;
  logic         alu_wr, alu_upd, alu_cy;
  logic         md_busy, md_done, md_fault, md_start, accept;
  logic         c_r, z_r, n_r, err_r;

  assign op     = op_e'(op_code);
  assign accept = op_valid && !md_busy;
  assign md_start = accept && ((op == OP_MUL) || (op == OP_DIV && !md_fault));

  acc_alu #(.W(W)) u_alu (
    .op(op), .ac(ac_r), .m(mem_operand),
    .res(alu_res), .wr_ac(alu_wr), .upd_flags(alu_upd), .cy(alu_cy)
  );

  acc_muldiv #(.W(W)) u_md (
    .clk(clk), .rst(rst), .start(md_start), .is_div(op == OP_DIV),
    .ac(ac_r), .mq(mq_r), .m(mem_operand),
    .div_fault(md_fault), .busy(md_busy), .done(md_done),
    .res_hi(md_hi), .res_lo(md_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_r     <= '0;
      mq_r     <= '0;
      c_r      <= 1'b0;
      z_r      <= 1'b0;
      n_r      <= 1'b0;
      err_r    <= 1'b0;
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_data  <= '0;
    end else begin
      st_valid <= 1'b0;
      if (md_done) begin
        ac_r <= md_lo;
        mq_r <= md_hi;
      end else if (accept) begin
        err_r <= 1'b0;
        if (op == OP_STORE) begin
          st_valid <= 1'b1;
          st_addr  <= mem_addr;
          st_data  <= ac_r;
        end
        if (op == OP_DIV && md_fault) err_r <= 1'b1;
        if (alu_wr) ac_r <= alu_res;
        if (alu_upd) begin
          c_r <= alu_cy;
          z_r <= (alu_res == '0);
          n_r <= alu_res[W-1];
        end
      end
    end
  end

  assign acc     = ac_r;
  assign mq      = mq_r;
  assign flag_c  = c_r;
  assign flag_z  = z_r;
  assign flag_n  = n_r;
  assign div_err = err_r;
  assign busy    = md_busy;

  // R9: busy holds until the result lands, and the register pair is frozen meanwhile
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (md_busy && !md_done) |=> md_busy);
  p_pair_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (md_busy && !md_done) |=> ($stable(ac_r) && $stable(mq_r)));
  // R10: a divide fault leaves the pair untouched and starts nothing
  p_fault_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_r) |-> ($stable(ac_r) && $stable(mq_r) && !md_busy));
  // R3: a store strobe only follows an accepted store
  p_store_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> $past(op_valid && !md_busy && op_code == 4'd2));
  // R4: zero flag matches the accumulator after add or subtract
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $past(accept && (op_code == 4'd3 || op_code == 4'd4)) |-> (z_r == (ac_r == '0)));
endmodule

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] mem_operand = '0;
  logic [7:0]  mem_addr = '0;
  logic [15:0] acc, mq, st_data;
  logic [7:0]  st_addr;
  logic        flag_c, flag_z, flag_n, div_err, busy, st_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_exec_unit i_acc_exec_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .mem_operand(mem_operand), .mem_addr(mem_addr),
    .acc(acc), .mq(mq), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
    .div_err(div_err), .busy(busy), .st_valid(st_valid),
    .st_addr(st_addr), .st_data(st_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] opnd, input logic [7:0] addr);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; mem_operand = opnd; mem_addr = addr;
    @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // {req, op, operand, exp acc, exp mq, exp {c,z,n}}
  localparam int NV = 23;
  localparam logic [58:0] VEC [NV] = '{
    {4'd2, 4'd1,  16'h1234, 16'h1234, 16'h0000, 3'b000}, // R2 load
    {4'd4, 4'd3,  16'h0001, 16'h1235, 16'h0000, 3'b000}, // R4 add
    {4'd4, 4'd3,  16'hEDCB, 16'h0000, 16'h0000, 3'b110}, // R4 add with carry to zero
    {4'd4, 4'd4,  16'h0001, 16'hFFFF, 16'h0000, 3'b101}, // R4 subtract with borrow
    {4'd5, 4'd5,  16'h0F0F, 16'h0F0F, 16'h0000, 3'b101}, // R5 and, flags kept
    {4'd5, 4'd6,  16'hF000, 16'hFF0F, 16'h0000, 3'b101}, // R5 or
    {4'd5, 4'd7,  16'h00FF, 16'hFFF0, 16'h0000, 3'b101}, // R5 xor
    {4'd5, 4'd8,  16'h1234, 16'h000F, 16'h0000, 3'b101}, // R5 not ignores operand
    {4'd6, 4'd9,  16'h0004, 16'h00F0, 16'h0000, 3'b101}, // R6 shl
    {4'd2, 4'd1,  16'h8010, 16'h8010, 16'h0000, 3'b101}, // R2 load
    {4'd6, 4'd11, 16'h0004, 16'hF801, 16'h0000, 3'b101}, // R6 sar keeps sign
    {4'd6, 4'd10, 16'h0004, 16'h0F80, 16'h0000, 3'b101}, // R6 shr zero fill
    {4'd2, 4'd1,  16'h6000, 16'h6000, 16'h0000, 3'b101}, // R2 load
    {4'd7, 4'd12, 16'h6000, 16'h0000, 16'h2400, 3'b101}, // R7 square
    {4'd2, 4'd1,  16'h0064, 16'h0064, 16'h2400, 3'b101}, // R2 load keeps mq
    {4'd7, 4'd12, 16'h0007, 16'h02BC, 16'h0000, 3'b101}, // R7 100*7
    {4'd8, 4'd13, 16'h0009, 16'h004D, 16'h0007, 3'b101}, // R8 700/9
    {4'd2, 4'd1,  16'hFD44, 16'hFD44, 16'h0007, 3'b101}, // R2 load -700
    {4'd7, 4'd12, 16'h0001, 16'hFD44, 16'hFFFF, 3'b101}, // R7 sign extend via *1
    {4'd8, 4'd13, 16'h0009, 16'hFFB3, 16'hFFF9, 3'b101}, // R8 -700/9
    {4'd2, 4'd1,  16'hFFFD, 16'hFFFD, 16'hFFF9, 3'b101}, // R2 load -3
    {4'd7, 4'd12, 16'h0005, 16'hFFF1, 16'hFFFF, 3'b101}, // R7 -3*5
    {4'd7, 4'd12, 16'h8000, 16'h8000, 16'h0007, 3'b101}  // R7 -15*-32768
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bcnt;
    repeat (3) @(negedge clk);
    // R1: reset state, checked during reset
    chk("R1 acc", {16'h0, acc}, 32'h0);
    chk("R1 mq", {16'h0, mq}, 32'h0);
    chk("R1 status", {25'h0, flag_c, flag_z, flag_n, div_err, busy, st_valid, 1'b0},
        32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {acc, mq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      v = VEC[i];
      issue(v[54:51], v[50:35], 8'h00);
      chk($sformatf("R%0d vec%0d acc", v[58:55], i), {16'h0, acc}, {16'h0, v[34:19]});
      chk($sformatf("R%0d vec%0d mq", v[58:55], i), {16'h0, mq}, {16'h0, v[18:3]});
      chk($sformatf("R%0d vec%0d flags", v[58:55], i), {29'h0, flag_c, flag_z, flag_n},
          {29'h0, v[2:0]});
    end

    // R10: divide by zero
    issue(4'd13, 16'h0000, 8'h00);
    chk("R10 zero div err", {31'h0, div_err}, 32'h1);
    chk("R10 zero div pair", {mq, acc}, 32'h0007_8000);
    chk("R10 zero div no busy", {31'h0, busy}, 32'h0);
    // R10: next accepted op clears the flag
    issue(4'd0, 16'h0000, 8'h00);
    chk("R10 err cleared", {31'h0, div_err}, 32'h0);
    // R10: quotient overflow (upper half 7 >= 3)
    issue(4'd13, 16'h0003, 8'h00);
    chk("R10 overflow err", {31'h0, div_err}, 32'h1);
    chk("R10 overflow pair", {mq, acc}, 32'h0007_8000);

    // R3: store strobe
    issue(4'd1, 16'hBEEF, 8'h00);
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd2; mem_operand = 16'h1111; mem_addr = 8'h2A;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R3 st_valid", {31'h0, st_valid}, 32'h1);
    chk("R3 st_addr", {24'h0, st_addr}, 32'h2A);
    chk("R3 st_data", {16'h0, st_data}, 32'hBEEF);
    chk("R3 acc kept", {16'h0, acc}, 32'hBEEF);
    @(negedge clk);
    chk("R3 single pulse", {31'h0, st_valid}, 32'h0);

    // R9: busy length and ops ignored while busy
    issue(4'd1, 16'h0002, 8'h00);
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd12; mem_operand = 16'h0003;
    @(negedge clk);
    op_code = 4'd1; mem_operand = 16'h5555;
    bcnt = 0;
    while (busy) begin
      bcnt++;
      @(negedge clk);
      op_valid = 1'b0;
    end
    chk("R9 busy cycles", bcnt, 17);
    chk("R9 load ignored, product", {mq, acc}, 32'h0000_0006);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule